// File: doc/BRIEF.md
# Bursting Write Request Packer

This block is a 64-bit slave port that receives write bursts from a fabric master and turns each clean burst into one outbound memory-write request. A request is a header descriptor (start address, word count, and the byte masks of the first and last 32-bit words) followed by a stream of 64-bit payload beats. Every accepted beat enters an internal payload buffer. The descriptor is raised only once the final beat has been stored, so a packet never stalls partway through.

The block enforces strict burst rules. A burst count must be nonzero and must not exceed the active cap: `MAX_BEATS` beats by default, or `SMALL_BEATS` beats when `cap_small` is high. Inner beats must enable all eight bytes. No beat may enable zero bytes. The write strobe may not drop in the middle of a burst while the port is ready. A burst that breaks any of these rules is discarded completely, and a sticky error flag is set. Software clears that flag with `err_clr`. Backpressure uses `waitreq`, which follows the usual memory-mapped rules.

Top module: `wr_burst_packer`

## Requirements
- R1: A beat is consumed on a clock edge where `wr` is high and `waitreq` is low. For a legal beat, `waitreq` is high when the payload buffer already holds `DEPTH` beats, or when the beat is the last of its burst and a descriptor is still waiting in the output slot. Buffer occupancy never exceeds `DEPTH`.
- R2: `addr` and `burstcount` are taken from the first consumed beat of a burst. Their values on later beats change nothing.
- R3: `hdr_first_be` is bits [3:0] of the first beat's enables when any of those bits is set, and `hdr_addr` is then the captured address. Otherwise `hdr_first_be` is bits [7:4] and `hdr_addr` is the captured address plus 4.
- R4: `hdr_last_be` is bits [7:4] of the last beat's enables when any of those bits is set, and bits [3:0] otherwise. A packet of exactly one 32-bit word reports `hdr_last_be` = 0.
- R5: `hdr_len` is 2 × burst count, minus 1 if the low half of the first beat is empty, minus 1 if the high half of the last beat is empty.
- R6: A burst count of 0, or one above the active cap, drops the burst and sets `err_flag`.
- R7: A beat with enables 0x00, or an inner beat with enables other than 0xFF, drops the burst and sets `err_flag`. A single-beat burst accepts any nonzero mask.
- R8: A cycle inside a burst with `wr` low and `waitreq` low ends the burst at once, drops it, and sets `err_flag`.
- R9: `hdr_valid` rises in the cycle after the last beat of a clean burst is consumed. The payload beats then appear in order with `pl_last` set only on the final beat. No header or beat of a dropped burst ever appears.
- R10: `err_flag` stays high until `err_clr` is sampled high. A new error in the same cycle wins.
- R11: While `hdr_valid` is high and `hdr_ready` is low, the header fields hold steady. While `pl_valid` is high and `pl_ready` is low, `pl_data` and `pl_last` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_small | input | 1 | Selects the smaller burst cap |
| err_clr | input | 1 | Clears the sticky error flag |
| wr | input | 1 | Write strobe from the master |
| addr | input | AW | Byte start address (first beat only) |
| burstcount | input | BCW | Burst length in 64-bit beats (first beat only) |
| wdata | input | 64 | Write data |
| be | input | 8 | Byte enables of the current beat |
| waitreq | output | 1 | Beat not consumed this cycle |
| hdr_valid | output | 1 | Descriptor available |
| hdr_ready | input | 1 | Downstream takes the descriptor |
| hdr_addr | output | AW | Address of the first enabled 32-bit word |
| hdr_len | output | BCW+1 | Payload length in 32-bit words |
| hdr_first_be | output | 4 | Byte mask of the first word |
| hdr_last_be | output | 4 | Byte mask of the last word |
| pl_valid | output | 1 | Payload beat available |
| pl_ready | input | 1 | Downstream takes the beat |
| pl_data | output | 64 | Payload beat |
| pl_last | output | 1 | Final beat of a packet |
| err_flag | output | 1 | Sticky burst error |

## Verification
The assertions check the following on every cycle:
- the buffer occupancy bound;
- the hold rules on both output streams;
- the persistence of the error flag;
- the header invariants: a nonzero first mask, a nonzero length, and an empty last mask for one-word packets.

Only the bench's scenarios can show the rest:
- that the mask and length arithmetic is correct for every single-beat mask and for a grid of multi-beat edge masks;
- that bad bursts leave no trace downstream;
- that late-beat address and count values are ignored;
- that both causes of `waitreq` stall the correct beat.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

  // Mask of the lowest enabled 32-bit word within a beat.
  function automatic logic [3:0] lead_word_be(input logic [7:0] be);
    return (be[3:0] != 4'h0) ? be[3:0] : be[7:4];
  endfunction

  // True when the lower word of a beat is unused, so the start moves up 4 bytes.
  function automatic logic lead_word_skip(input logic [7:0] be);
    return (be[3:0] == 4'h0);
  endfunction

  // Mask of the highest enabled word; a one-word packet reports zero.
  function automatic logic [3:0] tail_word_be(input logic [7:0] be, input logic one_beat);
    if (one_beat && ((be[3:0] == 4'h0) || (be[7:4] == 4'h0))) return 4'h0;
    return (be[7:4] != 4'h0) ? be[7:4] : be[3:0];
  endfunction

  function automatic logic inner_beat_ok(input logic [7:0] be);
    return (be == 8'hFF);
  endfunction

endpackage

// File: rtl/wbp_payload_buf.sv
module wbp_payload_buf #(
  parameter int DW    = 64,
  parameter int DEPTH = 512,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_last,
  input  logic          commit,
  input  logic          rollback,
  input  logic          pop,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic [PW-1:0] fill,
  output logic          full
);
  // DEPTH must be a power of two: pointers wrap with one extra lap bit.
  logic [DW:0]   store [DEPTH];
  logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr;
  logic [PW-1:0] wr_next;

  assign wr_next   = wr_ptr + {{IW{1'b0}}, push};
  assign out_valid = (rd_ptr != cm_ptr);
  assign {out_last, out_data} = store[rd_ptr[IW-1:0]];
  assign fill      = wr_ptr - rd_ptr;
  assign full      = (fill == PW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr[IW-1:0]] <= {push_last, push_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      cm_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (rollback)    wr_ptr <= cm_ptr;
      else             wr_ptr <= wr_next;
      if (commit)      cm_ptr <= wr_next;
      if (pop && out_valid) rd_ptr <= rd_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/wbp_burst_track.sv
module wbp_burst_track
  import wbp_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BCW         = 10,
  parameter int MAX_BEATS   = 512,
  parameter int SMALL_BEATS = 64,
  localparam int LW         = BCW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_small,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [BCW-1:0] burstcount,
  input  logic [7:0]     be,
  input  logic           buf_full,
  input  logic           slot_busy,
  output logic           waitreq,
  output logic           push,
  output logic           beat_is_last,
  output logic           done_ok,
  output logic           done_bad,
  output logic [AW-1:0]  pkt_addr,
  output logic [LW-1:0]  pkt_len,
  output logic [3:0]     pkt_first_be,
  output logic [3:0]     pkt_last_be
);
  function automatic logic [LW-1:0] word_len(input logic [BCW-1:0] n,
                                             input logic skip_lo, input logic skip_hi);
    return {n, 1'b0} - LW'(skip_lo) - LW'(skip_hi);
  endfunction

  logic           active_q, bad_q, skip_q;
  logic [BCW-1:0] cnt_q, idx_q;
  logic [AW-1:0]  base_q;
  logic [3:0]     fbe_q;

  logic           start, cnt_bad, be_bad, inner, kill, accept, gap;
  logic [BCW-1:0] cnt_eff, idx, cap_beats;
  logic [AW-1:0]  lead_addr;

  assign start     = !active_q;
  assign cnt_eff   = start ? burstcount : cnt_q;
  assign idx       = start ? '0 : idx_q;
  assign cap_beats = cap_small ? BCW'(SMALL_BEATS) : BCW'(MAX_BEATS);
  assign cnt_bad   = start && ((burstcount == '0) || (burstcount > cap_beats));
  assign beat_is_last = (cnt_eff == '0) || (idx == cnt_eff - BCW'(1));
  assign inner     = (idx != '0) && !beat_is_last;
  assign be_bad    = (be == 8'h00) || (inner && !inner_beat_ok(be));
  assign kill      = bad_q || cnt_bad || be_bad;

  // A doomed beat is swallowed without stalling; a clean one waits for space.
  assign waitreq   = !kill && (buf_full || (beat_is_last && slot_busy));
  assign accept    = wr && !waitreq;
  assign push      = accept && !kill;
  assign gap       = active_q && !wr && !waitreq;
  assign done_ok   = accept && beat_is_last && !kill;
  assign done_bad  = (accept && beat_is_last && kill) || gap;

  assign lead_addr    = addr + (lead_word_skip(be) ? AW'(4) : AW'(0));
  assign pkt_addr     = start ? lead_addr : base_q;
  assign pkt_first_be = start ? lead_word_be(be) : fbe_q;
  assign pkt_last_be  = tail_word_be(be, start);
  assign pkt_len      = word_len(cnt_eff, start ? lead_word_skip(be) : skip_q,
                                 (be[7:4] == 4'h0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bad_q    <= 1'b0;
      skip_q   <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      base_q   <= '0;
      fbe_q    <= '0;
    end else if (gap) begin
      active_q <= 1'b0;
      bad_q    <= 1'b0;
    end else if (accept) begin
      active_q <= !beat_is_last;
      bad_q    <= kill && !beat_is_last;
      idx_q    <= idx + BCW'(1);
      if (start) begin
        cnt_q  <= burstcount;
        base_q <= lead_addr;
        fbe_q  <= lead_word_be(be);
        skip_q <= lead_word_skip(be);
      end
    end
  end

endmodule

// File: rtl/wr_burst_packer.sv
module wr_burst_packer #(
  parameter int AW          = 32,
  parameter int BCW         = 10,
  parameter int DEPTH       = 512,
  parameter int MAX_BEATS   = 512,
  parameter int SMALL_BEATS = 64,
  localparam int LW         = BCW + 1,
  localparam int PW         = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_small,
  input  logic           err_clr,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [BCW-1:0] burstcount,
  input  logic [63:0]    wdata,
  input  logic [7:0]     be,
  output logic           waitreq,
  output logic           hdr_valid,
  input  logic           hdr_ready,
  output logic [AW-1:0]  hdr_addr,
  output logic [LW-1:0]  hdr_len,
  output logic [3:0]     hdr_first_be,
  output logic [3:0]     hdr_last_be,
  output logic           pl_valid,
  input  logic           pl_ready,
  output logic [63:0]    pl_data,
  output logic           pl_last,
  output logic           err_flag
);
  // Internal events, named for the bound checker.
  logic           push, beat_is_last, done_ok, done_bad, buf_full;
  logic [PW-1:0]  buf_fill;
  logic [AW-1:0]  pkt_addr;
  logic [LW-1:0]  pkt_len;
  logic [3:0]     pkt_first_be, pkt_last_be;

  wbp_burst_track #(
    .AW(AW), .BCW(BCW), .MAX_BEATS(MAX_BEATS), .SMALL_BEATS(SMALL_BEATS)
  ) u_track (
    .clk, .rst_n, .cap_small, .wr, .addr, .burstcount, .be,
    .buf_full     (buf_full),
    .slot_busy    (hdr_valid),
    .waitreq      (waitreq),
    .push         (push),
    .beat_is_last (beat_is_last),
    .done_ok      (done_ok),
    .done_bad     (done_bad),
    .pkt_addr     (pkt_addr),
    .pkt_len      (pkt_len),
    .pkt_first_be (pkt_first_be),
    .pkt_last_be  (pkt_last_be)
  );

  wbp_payload_buf #(.DW(64), .DEPTH(DEPTH)) u_buf (
    .clk, .rst_n,
    .push      (push),
    .push_data (wdata),
    .push_last (beat_is_last),
    .commit    (done_ok),
    .rollback  (done_bad),
    .pop       (pl_ready),
    .out_valid (pl_valid),
    .out_data  (pl_data),
    .out_last  (pl_last),
    .fill      (buf_fill),
    .full      (buf_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_valid    <= 1'b0;
      hdr_addr     <= '0;
      hdr_len      <= '0;
      hdr_first_be <= '0;
      hdr_last_be  <= '0;
    end else if (done_ok) begin
      hdr_valid    <= 1'b1;
      hdr_addr     <= pkt_addr;
      hdr_len      <= pkt_len;
      hdr_first_be <= pkt_first_be;
      hdr_last_be  <= pkt_last_be;
    end else if (hdr_ready) begin
      hdr_valid    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        err_flag <= 1'b0;
    else if (done_bad) err_flag <= 1'b1;
    else if (err_clr)  err_flag <= 1'b0;
  end

endmodule

// File: rtl/wbp_checker.sv
module wbp_checker #(
  parameter int DEPTH = 512,
  parameter int AW    = 32,
  parameter int BCW   = 10,
  localparam int LW   = BCW + 1,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          err_clr,
  input logic          err_flag,
  input logic          hdr_valid,
  input logic          hdr_ready,
  input logic [AW-1:0] hdr_addr,
  input logic [LW-1:0] hdr_len,
  input logic [3:0]    hdr_first_be,
  input logic [3:0]    hdr_last_be,
  input logic          pl_valid,
  input logic          pl_ready,
  input logic [63:0]   pl_data,
  input logic          pl_last,
  input logic [PW-1:0] buf_fill
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    buf_fill <= PW'(DEPTH)); // R1

  AST_LEAD_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> hdr_first_be != 4'h0); // R3

  AST_ONE_WORD_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_len == LW'(1)) |-> hdr_last_be == 4'h0); // R4

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> hdr_len != '0); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag); // R10

  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_ready) |=> hdr_valid && $stable(hdr_addr) && $stable(hdr_len)
      && $stable(hdr_first_be) && $stable(hdr_last_be)); // R11

  AST_PL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && !pl_ready) |=> pl_valid && $stable(pl_data) && $stable(pl_last)); // R11

endmodule

bind wr_burst_packer wbp_checker #(.DEPTH(DEPTH), .AW(AW), .BCW(BCW)) i_wbp_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .err_clr      (err_clr),
  .err_flag     (err_flag),
  .hdr_valid    (hdr_valid),
  .hdr_ready    (hdr_ready),
  .hdr_addr     (hdr_addr),
  .hdr_len      (hdr_len),
  .hdr_first_be (hdr_first_be),
  .hdr_last_be  (hdr_last_be),
  .pl_valid     (pl_valid),
  .pl_ready     (pl_ready),
  .pl_data      (pl_data),
  .pl_last      (pl_last),
  .buf_fill     (buf_fill)
);

// File: tb/test_wr_burst_packer.sv
module test_wr_burst_packer;
  localparam int AW = 32, BCW = 10, DEPTH = 8, MAXB = 8, SMALLB = 2, LW = BCW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cap_small = 1'b0, err_clr = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [BCW-1:0] burstcount = '0;
  logic [63:0] wdata = '0;
  logic [7:0] be = '0;
  logic hdr_ready = 1'b1, pl_ready = 1'b1;
  logic waitreq, hdr_valid, pl_valid, pl_last, err_flag;
  logic [AW-1:0] hdr_addr;
  logic [LW-1:0] hdr_len;
  logic [3:0] hdr_first_be, hdr_last_be;
  logic [63:0] pl_data;

  always #10 clk = ~clk;

  wr_burst_packer #(.AW(AW), .BCW(BCW), .DEPTH(DEPTH), .MAX_BEATS(MAXB), .SMALL_BEATS(SMALLB))
  i_wr_burst_packer (
    .clk, .rst_n, .cap_small, .err_clr, .wr, .addr, .burstcount, .wdata, .be,
    .waitreq, .hdr_valid, .hdr_ready, .hdr_addr, .hdr_len, .hdr_first_be, .hdr_last_be,
    .pl_valid, .pl_ready, .pl_data, .pl_last, .err_flag
  );

  int checks = 0, errors = 0, tag = 0;
  bit done = 0;

  logic [AW-1:0] qa[$];
  logic [LW-1:0] ql[$];
  logic [3:0] qf[$], qb[$];
  logic [63:0] qd[$];
  logic qe[$];

  // Samples settled values that the next rising edge will act on.
  always begin
    @(negedge clk); #5;
    if (rst_n) begin
      if (hdr_valid && hdr_ready) begin
        qa.push_back(hdr_addr); ql.push_back(hdr_len);
        qf.push_back(hdr_first_be); qb.push_back(hdr_last_be);
      end
      if (pl_valid && pl_ready) begin
        qd.push_back(pl_data); qe.push_back(pl_last);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  function automatic logic [63:0] beat_word(input int t, input int i);
    return {16'hC0DE, t[15:0], 16'h5A00, i[15:0]};
  endfunction

  task automatic send_burst(input logic [AW-1:0] a, input int n, input logic [BCW-1:0] bc,
                            input logic [7:0] bf, input logic [7:0] bm, input logic [7:0] bl,
                            input int gap_at, input bit ok, input string req);
    tag++;
    for (int i = 0; i < n; i++) begin
      tick();
      wr = 1'b1;
      addr = (i == 0) ? a : ~a;                   // R2: late values must be ignored
      burstcount = (i == 0) ? bc : ~bc;
      wdata = beat_word(tag, i);
      be = (i == 0) ? bf : ((i == n - 1) ? bl : bm);
      #1;
      while (waitreq) tick();
      if (i == gap_at) begin
        tick(); wr = 1'b0;
        break;
      end
    end
    tick(); wr = 1'b0;
    chk(hdr_valid === ok, {req, " R9 header timing"}, 64'(hdr_valid), 64'(ok));
    repeat (n + 3) tick();
  endtask

  task automatic check_pkt(input logic [AW-1:0] a, input int n, input logic [7:0] bf,
                           input logic [7:0] bl, input int t, input string req);
    int first_w, last_w, exp_len;
    logic [7:0] lb;
    logic [3:0] exp_lbe;
    lb = (n == 1) ? bf : bl;
    first_w = (bf[3:0] == 4'h0) ? 1 : 0;
    last_w  = 2 * n - ((lb[7:4] == 4'h0) ? 2 : 1);
    exp_len = last_w - first_w + 1;
    exp_lbe = (exp_len == 1) ? 4'h0 : ((last_w % 2 == 1) ? lb[7:4] : lb[3:0]);
    if (qa.size() == 0) chk(0, {req, " R9 header missing"}, 0, 1);
    else begin
      logic [AW-1:0] ga; logic [LW-1:0] gl; logic [3:0] gf, gb;
      ga = qa.pop_front(); gl = ql.pop_front(); gf = qf.pop_front(); gb = qb.pop_front();
      chk(ga == a + AW'(4 * first_w), {req, " R3 addr"}, 64'(ga), 64'(a + AW'(4 * first_w)));
      chk(gf == (first_w == 1 ? bf[7:4] : bf[3:0]), {req, " R3 first_be"}, 64'(gf),
          64'(first_w == 1 ? bf[7:4] : bf[3:0]));
      chk(gb == exp_lbe, {req, " R4 last_be"}, 64'(gb), 64'(exp_lbe));
      chk(int'(gl) == exp_len, {req, " R5 len"}, 64'(gl), 64'(exp_len));
    end
    for (int i = 0; i < n; i++) begin
      if (qd.size() == 0) begin chk(0, {req, " R9 beat missing"}, 64'(i), 64'(n)); break; end
      else begin
        logic [63:0] d; logic e;
        d = qd.pop_front(); e = qe.pop_front();
        chk(d == beat_word(t, i) && e == (i == n - 1), {req, " R9 payload"}, d, beat_word(t, i));
      end
    end
  endtask

  task automatic check_empty(input string req);
    chk(qa.size() == 0 && qd.size() == 0, {req, " nothing emitted"},
        64'(qa.size() + qd.size()), 0);
  endtask

  task automatic clear_err();
    tick(); err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk(err_flag == 1'b0, "R10 clear", 64'(err_flag), 0);
  endtask

  task automatic bad_case(input logic [AW-1:0] a, input int n, input logic [BCW-1:0] bc,
                          input logic [7:0] bf, input logic [7:0] bm, input logic [7:0] bl,
                          input int gap_at, input string req);
    send_burst(a, n, bc, bf, bm, bl, gap_at, 1'b0, req);
    check_empty(req);
    chk(err_flag == 1'b1, {req, " err set"}, 64'(err_flag), 1);
    clear_err();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] keep_a; logic [63:0] keep_d; int t1, t2;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(hdr_valid == 0 && pl_valid == 0 && err_flag == 0 && waitreq == 0, "reset state",
        {60'd0, hdr_valid, pl_valid, err_flag, waitreq}, 0);

    // R3 R4 R5: every nonzero mask on a single-beat burst (R7 single beat any mask)
    for (int m = 1; m < 256; m++) begin
      send_burst(32'h1000 + 32'(m * 8), 1, 10'd1, 8'(m), 8'hFF, 8'(m), -1, 1'b1, "single");
      check_pkt(32'h1000 + 32'(m * 8), 1, 8'(m), 8'(m), tag, "single");
    end

    // R2 R3 R4 R5: grid of edge masks over multi-beat counts, full cap
    for (int n = 2; n <= MAXB; n++)
      for (int f = 0; f < 5; f++)
        for (int l = 0; l < 5; l++) begin
          logic [7:0] fm, lm;
          fm = (f == 0) ? 8'h01 : (f == 1) ? 8'h0F : (f == 2) ? 8'hF0 : (f == 3) ? 8'h80 : 8'hFF;
          lm = (l == 0) ? 8'h01 : (l == 1) ? 8'h0F : (l == 2) ? 8'h10 : (l == 3) ? 8'hF0 : 8'hFF;
          send_burst(32'h8000 + 32'(n * 256), n, BCW'(n), fm, 8'hFF, lm, -1, 1'b1, "multi");
          check_pkt(32'h8000 + 32'(n * 256), n, fm, lm, tag, "multi");
        end

    // R6: burst-count limits under both caps
    bad_case(32'h200, 1, 10'd0, 8'hFF, 8'hFF, 8'hFF, -1, "R6 zero count");
    bad_case(32'h200, MAXB + 1, BCW'(MAXB + 1), 8'hFF, 8'hFF, 8'hFF, -1, "R6 above big cap");
    cap_small = 1'b1;
    bad_case(32'h200, SMALLB + 1, BCW'(SMALLB + 1), 8'hFF, 8'hFF, 8'hFF, -1, "R6 above small cap");
    send_burst(32'h300, SMALLB, BCW'(SMALLB), 8'hF0, 8'hFF, 8'h0F, -1, 1'b1, "R6 at small cap");
    check_pkt(32'h300, SMALLB, 8'hF0, 8'h0F, tag, "R6 at small cap");
    cap_small = 1'b0;

    // R7: illegal masks
    bad_case(32'h400, 3, 10'd3, 8'hFF, 8'h7F, 8'hFF, -1, "R7 inner not full");
    bad_case(32'h400, 2, 10'd2, 8'hFF, 8'hFF, 8'h00, -1, "R7 last empty");
    bad_case(32'h400, 2, 10'd2, 8'h00, 8'hFF, 8'hFF, -1, "R7 first empty");
    bad_case(32'h400, 1, 10'd1, 8'h00, 8'h00, 8'h00, -1, "R7 single empty");

    // R8: write strobe drops mid-burst
    bad_case(32'h500, 4, 10'd4, 8'hFF, 8'hFF, 8'hFF, 1, "R8 gap");
    send_burst(32'h600, 3, 10'd3, 8'hFF, 8'hFF, 8'hFF, -1, 1'b1, "R8 recovery");
    check_pkt(32'h600, 3, 8'hFF, 8'hFF, tag, "R8 recovery");

    // R10: flag holds without a clear
    send_burst(32'h700, 1, 10'd0, 8'hFF, 8'hFF, 8'hFF, -1, 1'b0, "R10 set");
    repeat (6) tick();
    chk(err_flag == 1'b1, "R10 holds", 64'(err_flag), 1);
    clear_err();

    // R1 R11: full buffer and busy descriptor slot
    tick(); hdr_ready = 1'b0; pl_ready = 1'b0;
    send_burst(32'h900, DEPTH, BCW'(DEPTH), 8'hFF, 8'hFF, 8'hFF, -1, 1'b1, "R1 fill");
    t1 = tag;
    keep_a = hdr_addr; keep_d = pl_data;
    repeat (3) tick();
    chk(hdr_valid && hdr_addr == keep_a, "R11 header hold", 64'(hdr_addr), 64'(keep_a));
    chk(pl_valid && pl_data == keep_d, "R11 payload hold", pl_data, keep_d);
    tag++; t2 = tag;
    tick(); wr = 1'b1; addr = 32'hA00; burstcount = 10'd1; be = 8'h0F; wdata = beat_word(t2, 0);
    #1;
    chk(waitreq == 1'b1, "R1 stall on full", 64'(waitreq), 1);
    pl_ready = 1'b1;
    repeat (DEPTH + 3) tick();
    chk(waitreq == 1'b1, "R1 stall on busy slot", 64'(waitreq), 1);
    hdr_ready = 1'b1;
    #1;
    while (waitreq) tick();
    tick(); wr = 1'b0;
    repeat (5) tick();
    check_pkt(32'h900, DEPTH, 8'hFF, 8'hFF, t1, "R1 first");
    check_pkt(32'hA00, 1, 8'h0F, 8'h0F, t2, "R1 second");
    check_empty("end");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule